// File: doc/BRIEF.md
# Adjustable Raster Sync Generator

This block derives the horizontal and vertical sync pulses for a character-based raster monitor from a single dot clock. It counts dots within a character cell, character cells within a scan line, and scan lines within a frame. It drives an active-high line sync and an active-low frame sync with fixed widths. Downstream logic, such as the character fetch and the pixel shifter, can use the current character column and the current scan line, which are also output.

A rate input chooses between a short frame of 264 lines and a long frame of 312 lines. Two 3-bit offset inputs move the picture on screen by delaying the sync pulses. The vertical offset moves the frame pulse in steps of one text row of 12 lines. The horizontal offset moves the line pulse in steps of two character cells. The block samples the rate and both offsets once per frame, at a fixed point where no sync pulse can be active. A setting change therefore never produces a cut-short or doubled pulse.

At default parameters the dot clock is 10.1376 MHz. Each line is 80 cells of 8 dots, which is 640 dot clocks and gives a 15.84 kHz line rate.

Top module: `raster_sync_gen`

## Requirements
- R1: `dot` counts 0 to DOTS_PER_CHAR-1 inside a cell. On each wrap of `dot`, `char_col` advances by one and returns to 0 after CHARS_PER_LINE-1. When `char_col` wraps, `scan_line` advances by one. `char_col` and `scan_line` hold steady at all other times.
- R2: `hsync` is active high for exactly HSYNC_CHARS cells, which is 80 dot clocks at defaults. It rises at dot 0 of column HSYNC_BASE_COL + HSTEP_CHARS × hoff, with hoff read as an unsigned 3-bit value. The default base column is 64 and the step is 2 cells.
- R3: `vsync_n` is active low for exactly VSYNC_LINES lines, which is 11 at defaults. It falls at column 0, dot 0 of line VSYNC_BASE_LINE + ROW_LINES × voff, with voff read as an unsigned 3-bit value and ROW_LINES = 12.
- R4: A frame is LINES_60HZ lines (264) while the latched rate is 0, and LINES_50HZ lines (312) while it is 1. `scan_line` returns to 0 after the last line.
- R5: The block samples `mode_50hz`, `hoff` and `voff` only at line 0, dot 0 of column LATCH_COL. LATCH_COL is the first column after the latest possible end of a line pulse, which is column 8 at defaults. Values present at any other time have no effect on the sync outputs or on the frame length.
- R6: Synchronous active-high `rst` clears all counters, drives `hsync` to 0 and `vsync_n` to 1, and selects the 264-line rate with zero offsets. The first frame after reset ignores the inputs and uses these settings. Its first `hsync` rise therefore comes HSYNC_BASE_COL × DOTS_PER_CHAR clocks after reset is released.
- R7: When the pulse start plus its width passes the end of a line, the pulse continues without a break into the first columns of the next line, including across a frame boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_50hz | input | 1 | Frame rate select: 0 gives the short frame, 1 the long frame |
| hoff | input | 3 | Horizontal delay in steps of two cells |
| voff | input | 3 | Vertical delay in steps of one text row |
| hsync | output | 1 | Line sync, active high |
| vsync_n | output | 1 | Frame sync, active low |
| char_col | output | 7 | Current character column |
| scan_line | output | 9 | Current scan line in the frame |

## Verification
The bench runs a reduced geometry for over a hundred frames. It steps through all eight horizontal and all eight vertical offsets under both rates, and compares every output on every clock with an arithmetic model. It changes the inputs in the middle of each frame. A design that sampled them early would move a pulse mid-frame or emit two pulses in one line, and the checks on pulses per frame and pulse width catch this. Large horizontal offsets make the line pulse run past the end of the line. A design without modular wrap would cut that pulse short and fail the width check. The bench also times the first pulse after reset against the nominal column and measures each frame's length against the latched rate.

// File: rtl/raster_sync_pkg.sv
package raster_sync_pkg;

    typedef enum logic {
        RATE_SHORT = 1'b0,
        RATE_LONG  = 1'b1
    } frame_rate_e;

    // width of a counter that must hold values 0..n-1
    function automatic int cnt_bits(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    // distance from start to pos going forward on a ring of size modulus
    function automatic int ring_dist(input int pos, input int start, input int modulus);
        return (pos >= start) ? (pos - start) : (pos + modulus - start);
    endfunction

endpackage

// File: rtl/raster_hcount.sv
module raster_hcount #(
    parameter int DOTS_PER_CHAR  = 8,
    parameter int CHARS_PER_LINE = 80,
    parameter int DOT_W          = 3,
    parameter int COL_W          = 7
) (
    input  logic             clk,
    input  logic             rst,
    output logic [DOT_W-1:0] dot,
    output logic [COL_W-1:0] col,
    output logic [DOT_W-1:0] dot_nx,
    output logic [COL_W-1:0] col_nx,
    output logic             line_end
);

    typedef struct packed {
        logic [DOT_W-1:0] dot;
        logic [COL_W-1:0] col;
    } hstate_t;

    localparam logic [DOT_W-1:0] DOT_LAST = DOT_W'(DOTS_PER_CHAR - 1);
    localparam logic [COL_W-1:0] COL_LAST = COL_W'(CHARS_PER_LINE - 1);

    hstate_t h_q, h_d;
    logic    line_end_d;

    always_comb begin
        h_d        = h_q;
        line_end_d = 1'b0;
        if (h_q.dot == DOT_LAST) begin
            h_d.dot = '0;
            if (h_q.col == COL_LAST) begin
                h_d.col    = '0;
                line_end_d = 1'b1;
            end else begin
                h_d.col = h_q.col + 1'b1;
            end
        end else begin
            h_d.dot = h_q.dot + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) h_q <= '0;
        else     h_q <= h_d;
    end

    assign dot      = h_q.dot;
    assign col      = h_q.col;
    assign dot_nx   = h_d.dot;
    assign col_nx   = h_d.col;
    assign line_end = line_end_d;

    // R1
    col_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (h_q.dot != DOT_LAST) |=> $stable(h_q.col));

endmodule

// File: rtl/raster_vcount.sv
module raster_vcount
    import raster_sync_pkg::*;
#(
    parameter int LINES_60HZ = 264,
    parameter int LINES_50HZ = 312,
    parameter int LINE_W     = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_end,
    input  frame_rate_e       rate,
    output logic [LINE_W-1:0] line,
    output logic [LINE_W-1:0] line_nx,
    output logic              frame_end
);

    logic [LINE_W-1:0] line_q, line_d;
    logic [LINE_W-1:0] line_last;
    logic              frame_end_d;

    always_comb begin
        line_last   = (rate == RATE_LONG) ? LINE_W'(LINES_50HZ - 1) : LINE_W'(LINES_60HZ - 1);
        frame_end_d = line_end && (line_q == line_last);
        if (frame_end_d)   line_d = '0;
        else if (line_end) line_d = line_q + 1'b1;
        else               line_d = line_q;
    end

    always_ff @(posedge clk) begin
        if (rst) line_q <= '0;
        else     line_q <= line_d;
    end

    assign line      = line_q;
    assign line_nx   = line_d;
    assign frame_end = frame_end_d;

    // R4
    line_range_chk: assert property (@(posedge clk) disable iff (rst)
        line_q <= line_last);

endmodule

// File: rtl/raster_sync_gen.sv
module raster_sync_gen
    import raster_sync_pkg::*;
#(
    parameter int DOTS_PER_CHAR   = 8,
    parameter int CHARS_PER_LINE  = 80,
    parameter int HSYNC_CHARS     = 10,
    parameter int HSYNC_BASE_COL  = 64,
    parameter int HSTEP_CHARS     = 2,
    parameter int LINES_60HZ      = 264,
    parameter int LINES_50HZ      = 312,
    parameter int VSYNC_LINES     = 11,
    parameter int VSYNC_BASE_LINE = 168,
    parameter int ROW_LINES       = 12,
    parameter int OFS_W           = 3,
    parameter int COL_W           = cnt_bits(CHARS_PER_LINE),
    parameter int LINE_W          = cnt_bits((LINES_50HZ > LINES_60HZ) ? LINES_50HZ : LINES_60HZ)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_50hz,
    input  logic [OFS_W-1:0]  hoff,
    input  logic [OFS_W-1:0]  voff,
    output logic              hsync,
    output logic              vsync_n,
    output logic [COL_W-1:0]  char_col,
    output logic [LINE_W-1:0] scan_line
);

    localparam int DOT_W     = cnt_bits(DOTS_PER_CHAR);
    localparam int OFS_MAX   = (1 << OFS_W) - 1;
    localparam int LATCH_COL = (HSYNC_BASE_COL + OFS_MAX * HSTEP_CHARS + HSYNC_CHARS) % CHARS_PER_LINE;

    typedef struct packed {
        logic [OFS_W-1:0] hoff;
        logic [OFS_W-1:0] voff;
        frame_rate_e      rate;
        logic             started;
        logic             hsync;
        logic             vsync_n;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{hoff: '0, voff: '0, rate: RATE_SHORT,
                                   started: 1'b0, hsync: 1'b0, vsync_n: 1'b1};

    logic [DOT_W-1:0]  dot, dot_nx;
    logic [COL_W-1:0]  col, col_nx;
    logic [LINE_W-1:0] line, line_nx;
    logic              line_end, frame_end;
    logic              take_settings;
    ctl_t              c_q, c_d;

    raster_hcount #(
        .DOTS_PER_CHAR (DOTS_PER_CHAR),
        .CHARS_PER_LINE(CHARS_PER_LINE),
        .DOT_W         (DOT_W),
        .COL_W         (COL_W)
    ) u_hcount (
        .clk     (clk),
        .rst     (rst),
        .dot     (dot),
        .col     (col),
        .dot_nx  (dot_nx),
        .col_nx  (col_nx),
        .line_end(line_end)
    );

    raster_vcount #(
        .LINES_60HZ(LINES_60HZ),
        .LINES_50HZ(LINES_50HZ),
        .LINE_W    (LINE_W)
    ) u_vcount (
        .clk      (clk),
        .rst      (rst),
        .line_end (line_end),
        .rate     (c_q.rate),
        .line     (line),
        .line_nx  (line_nx),
        .frame_end(frame_end)
    );

    always_comb begin
        int hstart;
        int vstart;
        int hrel;
        int ln;
        c_d         = c_q;
        c_d.started = c_q.started | frame_end;
        take_settings = c_d.started && (line_nx == '0) &&
                        (col_nx == COL_W'(LATCH_COL)) && (dot_nx == '0);
        if (take_settings) begin
            c_d.hoff = hoff;
            c_d.voff = voff;
            c_d.rate = frame_rate_e'(mode_50hz);
        end
        hstart      = HSYNC_BASE_COL + int'(c_d.hoff) * HSTEP_CHARS;
        hrel        = ring_dist(int'(col_nx), hstart, CHARS_PER_LINE);
        c_d.hsync   = (hrel < HSYNC_CHARS);
        vstart      = VSYNC_BASE_LINE + int'(c_d.voff) * ROW_LINES;
        ln          = int'(line_nx);
        c_d.vsync_n = !((ln >= vstart) && (ln < vstart + VSYNC_LINES));
    end

    always_ff @(posedge clk) begin
        if (rst) c_q <= CTL_RESET;
        else     c_q <= c_d;
    end

    assign hsync     = c_q.hsync;
    assign vsync_n   = c_q.vsync_n;
    assign char_col  = col;
    assign scan_line = line;

    // R2
    hsync_cell_align_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(c_q.hsync) |-> (dot == '0));

    // R3
    vsync_line_align_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(c_q.vsync_n) |-> (dot == '0 && col == '0));

    // R5
    settings_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable({c_q.hoff, c_q.voff, c_q.rate}) |->
            (line == '0 && col == COL_W'(LATCH_COL) && dot == '0));

endmodule

// File: tb/raster_sync_gen_bench.sv
module raster_sync_gen_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DPC   = 2;
    localparam int CH    = 24;
    localparam int HSW   = 3;
    localparam int HB    = 8;
    localparam int HSTEP = 2;
    localparam int L60   = 22;
    localparam int L50   = 26;
    localparam int VSW   = 3;
    localparam int VB    = 4;
    localparam int ROW   = 2;
    localparam int LATCH = (HB + 7 * HSTEP + HSW) % CH;
    localparam int CW    = $clog2(CH);
    localparam int LW    = $clog2(L50);
    localparam int NF    = 110;
    localparam int WD    = 190000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          mode_50hz = 1'b0;
    logic [2:0]    hoff = '0;
    logic [2:0]    voff = '0;
    logic          hsync, vsync_n;
    logic [CW-1:0] char_col;
    logic [LW-1:0] scan_line;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    raster_sync_gen #(
        .DOTS_PER_CHAR(DPC), .CHARS_PER_LINE(CH), .HSYNC_CHARS(HSW),
        .HSYNC_BASE_COL(HB), .HSTEP_CHARS(HSTEP), .LINES_60HZ(L60),
        .LINES_50HZ(L50), .VSYNC_LINES(VSW), .VSYNC_BASE_LINE(VB),
        .ROW_LINES(ROW), .OFS_W(3)
    ) u_raster_sync_gen (
        .clk(clk), .rst(rst), .mode_50hz(mode_50hz), .hoff(hoff), .voff(voff),
        .hsync(hsync), .vsync_n(vsync_n), .char_col(char_col), .scan_line(scan_line)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // model state
    int m_dot, m_col, m_line, m_h, m_v, m_rate;
    bit m_started;

    initial begin
        int  t;
        int  frames;
        int  p_mode, p_h, p_v;
        int  start, rel, vst, exp_lines, max_line;
        bit  exp_hs, exp_vn, prev_hs, prev_vn, wrapped, first_seen;
        int  hs_run, vs_run, hs_rises, vs_falls;
        string htag;

        repeat (5) @(posedge clk);
        #1;
        // R6 reset state
        chk(char_col == '0, "R6 reset col", int'(char_col), 0);
        chk(scan_line == '0, "R6 reset line", int'(scan_line), 0);
        chk(hsync == 1'b0, "R6 reset hsync", int'(hsync), 0);
        chk(vsync_n == 1'b1, "R6 reset vsync_n", int'(vsync_n), 1);
        rst = 1'b0;
        // R6: values applied during the first frame must be ignored
        hoff = 3'd5; voff = 3'd3; mode_50hz = 1'b1;

        m_dot = 0; m_col = 0; m_line = 0; m_h = 0; m_v = 0; m_rate = 0; m_started = 0;
        t = 0; frames = 0; max_line = 0; first_seen = 0;
        prev_hs = 0; prev_vn = 1; hs_run = 0; vs_run = 0; hs_rises = 0; vs_falls = 0;

        while (frames < NF) begin
            @(posedge clk);
            p_mode = int'(mode_50hz); p_h = int'(hoff); p_v = int'(voff);
            #1;
            t++;
            wrapped   = 0;
            exp_lines = m_rate ? L50 : L60;
            m_dot++;
            if (m_dot == DPC) begin
                m_dot = 0; m_col++;
                if (m_col == CH) begin
                    m_col = 0; m_line++;
                    if (m_line == exp_lines) begin
                        m_line = 0; m_started = 1; wrapped = 1;
                    end
                end
            end
            if (m_started && m_line == 0 && m_col == LATCH && m_dot == 0) begin
                m_h = p_h; m_v = p_v; m_rate = p_mode;
            end

            start  = HB + m_h * HSTEP;
            rel    = (m_col >= start) ? m_col - start : m_col + CH - start;
            exp_hs = (rel < HSW);
            vst    = VB + m_v * ROW;
            exp_vn = !(m_line >= vst && m_line < vst + VSW);

            chk(int'(char_col) == m_col, "R1 char_col", int'(char_col), m_col);
            chk(int'(scan_line) == m_line, "R1 scan_line", int'(scan_line), m_line);
            if (!m_started)                                 htag = "R6 hsync first frame";
            else if (start + HSW > CH && m_col < start)     htag = "R7 hsync wrap";
            else                                            htag = "R2 hsync";
            chk(hsync == exp_hs, htag, int'(hsync), int'(exp_hs));
            chk(vsync_n == exp_vn, m_started ? "R3 vsync_n" : "R6 vsync_n first frame",
                int'(vsync_n), int'(exp_vn));

            // R6 first pulse at nominal column
            if (hsync && !first_seen) begin
                first_seen = 1;
                chk(t == HB * DPC, "R6 first hsync delay", t, HB * DPC);
            end

            // R4 frame length, R5 one pulse per line and one per frame
            if (wrapped) begin
                chk(max_line + 1 == exp_lines, "R4 frame length", max_line + 1, exp_lines);
                chk(hs_rises == exp_lines, "R5 hsync pulses per frame", hs_rises, exp_lines);
                chk(vs_falls == 1, "R5 vsync pulses per frame", vs_falls, 1);
                max_line = 0; hs_rises = 0; vs_falls = 0;
                frames++;
            end
            if (int'(scan_line) > max_line) max_line = int'(scan_line);

            // pulse widths (R2, R3, R7)
            if (hsync && !prev_hs) hs_rises++;
            if (hsync) hs_run++;
            else if (prev_hs) begin
                chk(hs_run == HSW * DPC, "R2 R7 hsync width", hs_run, HSW * DPC);
                hs_run = 0;
            end
            if (!vsync_n && prev_vn) vs_falls++;
            if (!vsync_n) vs_run++;
            else if (!prev_vn) begin
                chk(vs_run == VSW * CH * DPC, "R3 vsync width", vs_run, VSW * CH * DPC);
                vs_run = 0;
            end
            prev_hs = hsync; prev_vn = vsync_n;

            // new settings mid-frame, after the sample point: R5
            if (m_line == 2 && m_col == 0 && m_dot == 0) begin
                hoff      = 3'(frames % 8);
                voff      = 3'((frames * 3 + 1) % 8);
                mode_50hz = ((frames / 3) % 2) == 1;
            end
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (WD) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", WD, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule